// File: doc/BRIEF.md
# Bus-Master Disk DMA Register Window

This block is the software-visible register window of one bus-master disk DMA channel. A host reaches it through a byte-wide read/write port spanning eight byte addresses. Through it the host arms a descriptor-table base pointer, chooses the transfer direction, starts and stops the channel, and reads back channel status. The memory mover itself is not here. It receives `engStart` and `engToMem` from this block and returns single-cycle `engDone` and `engErr` strobes.

The status byte mixes three kinds of bits. Some are read-only, driven by the engine. Some are write-one-to-clear event bits. Two are plain read/write flags that record whether each of the two attached drives may use DMA. The event bit for completion also drives the `irq` output. Software judges a finished transfer as good when, after it clears start, the low three status bits read 100b: the event is set, there is no error and the channel is idle.

Top module: `busdma_regwin`

## Requirements
- R1: After reset every byte of the window reads 0x00, and `engStart`, `engToMem` and `irq` are low.
- R2: Writing offset 0 sets `engStart` to data bit 0. When start was low, it also sets `engToMem` to data bit 3, where 1 means device to memory. Reading offset 0 returns start in bit 0 and direction in bit 3, with every other bit zero.
- R3: While start is high, a write to offset 0 leaves the direction unchanged.
- R4: The active bit (status bit 0) is set by a command write that takes start from 0 to 1. It is cleared by a done or error strobe while active, and by any command write with bit 0 equal to 0.
- R5: While active, `engDone` sets status bit 2 and `engErr` sets status bit 1. Both strobes are ignored while not active.
- R6: Writing 1 to status bit 1 or bit 2 at offset 2 clears that bit, and writing 0 leaves it as it was. A strobe arriving in the same cycle as a clearing write wins, so the bit ends up set.
- R7: Status bits 5 and 6 are read/write flags for drive 0 and drive 1. Status writes cannot set bits 0 to 2. Bits 3, 4 and 7 always read zero.
- R8: `irq` equals status bit 2 at all times.
- R9: Offsets 4 to 7 hold the 32-bit table pointer, least significant byte at offset 4. Bits 1:0 of the pointer always read zero, and the pointer is presented on `prdBase`.
- R10: Offsets 1 and 3 read zero, and writes to them change no state.
- R11: After a done strobe followed by a write of 0 to start, status bits 2:0 read 100b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Write strobe for the register window |
| regAddr | input | 3 | Byte offset within the window |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regAddr`, combinational from state |
| engDone | input | 1 | Engine finished (one-cycle pulse) |
| engErr | input | 1 | Engine fault (one-cycle pulse) |
| engStart | output | 1 | Start level to the engine |
| engToMem | output | 1 | Direction to the engine, 1 = device to memory |
| prdBase | output | 32 | Descriptor table base, bits 1:0 zero |
| irq | output | 1 | Completion interrupt |

## Verification
Every write and every engine strobe takes effect at the rising edge where it is sampled. `regRdData`, `engStart`, `engToMem`, `prdBase` and `irq` therefore show the result one clock edge after the stimulus, because read data is decoded combinationally from registered state with no added latency. The bench drives inputs on the falling edge and releases them one nanosecond after the next rising edge. It then sweeps all eight offsets before the following falling edge and compares each byte with a reference model, which it advances once per edge.

// File: rtl/busdma_pkg.sv
package busdma_pkg;
  localparam int unsigned WIN_BYTES  = 8;
  localparam int unsigned ADDR_W     = $clog2(WIN_BYTES);
  localparam int unsigned PTR_BYTES  = 4;
  localparam int unsigned PTR_W      = PTR_BYTES * 8;
  localparam int unsigned PTR_ALIGN  = 2;
  localparam int unsigned OFS_CMD    = 0;
  localparam int unsigned OFS_STAT   = 2;
  localparam int unsigned OFS_PTR    = 4;

  typedef struct packed {
    logic [PTR_BYTES-1:0] ptrLaneWr;
    logic                 flagWr;
  } dpStrobes_t;
endpackage

// File: rtl/busdma_ctrl.sv
module busdma_ctrl
  import busdma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        wrLow,
  input  logic              engDone,
  input  logic              engErr,
  output dpStrobes_t        strobes,
  output logic              startQ,
  output logic              dirQ,
  output logic              activeQ,
  output logic              errQ,
  output logic              irqQ
);
  logic cmdWr, statWr;
  logic activeN, errN, irqN;

  assign cmdWr  = wrEn && (addr == ADDR_W'(OFS_CMD));
  assign statWr = wrEn && (addr == ADDR_W'(OFS_STAT));
  assign strobes.flagWr = statWr;

  for (genvar i = 0; i < PTR_BYTES; i++) begin : g_lane
    assign strobes.ptrLaneWr[i] = wrEn && (addr == ADDR_W'(OFS_PTR + i));
  end

  always_comb begin
    activeN = activeQ;
    errN    = errQ;
    irqN    = irqQ;
    if (statWr) begin
      if (wrLow[1]) errN = 1'b0;
      if (wrLow[2]) irqN = 1'b0;
    end
    if (activeQ && (engDone || engErr)) begin
      activeN = 1'b0;
      if (engDone) irqN = 1'b1;
      if (engErr)  errN = 1'b1;
    end
    if (cmdWr) begin
      if (wrLow[0] && !startQ) activeN = 1'b1;
      if (!wrLow[0])           activeN = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ  <= 1'b0;
      dirQ    <= 1'b0;
      activeQ <= 1'b0;
      errQ    <= 1'b0;
      irqQ    <= 1'b0;
    end else begin
      if (cmdWr) begin
        startQ <= wrLow[0];
        if (!startQ) dirQ <= wrLow[3];
      end
      activeQ <= activeN;
      errQ    <= errN;
      irqQ    <= irqN;
    end
  end
endmodule

// File: rtl/busdma_dp.sv
module busdma_dp
  import busdma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobes,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] addr,
  input  logic              startQ,
  input  logic              dirQ,
  input  logic              activeQ,
  input  logic              errQ,
  input  logic              irqQ,
  output logic [7:0]        rdData,
  output logic [PTR_W-1:0]  ptrOut
);
  localparam logic [7:0] LOW_MASK = 8'(~((1 << PTR_ALIGN) - 1));

  logic [PTR_W-1:0] ptrQ;
  logic [1:0]       flagQ;
  logic [7:0]       ptrByte [PTR_BYTES];

  for (genvar i = 0; i < PTR_BYTES; i++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (!rstN)                        ptrQ[i*8 +: 8] <= 8'h00;
      else if (strobes.ptrLaneWr[i]) begin
        if (i == 0) ptrQ[i*8 +: 8] <= wrData & LOW_MASK;
        else        ptrQ[i*8 +: 8] <= wrData;
      end
    end
    assign ptrByte[i] = ptrQ[i*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN)               flagQ <= 2'b00;
    else if (strobes.flagWr) flagQ <= wrData[6:5];
  end

  always_comb begin
    rdData = 8'h00;
    if (addr[ADDR_W-1]) rdData = ptrByte[addr[1:0]];
    else if (addr == ADDR_W'(OFS_CMD))  rdData = {4'b0000, dirQ, 2'b00, startQ};
    else if (addr == ADDR_W'(OFS_STAT)) rdData = {1'b0, flagQ, 2'b00, irqQ, errQ, activeQ};
  end

  assign ptrOut = ptrQ;
endmodule

// File: rtl/busdma_regwin.sv
module busdma_regwin
  import busdma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              engDone,
  input  logic              engErr,
  output logic              engStart,
  output logic              engToMem,
  output logic [PTR_W-1:0]  prdBase,
  output logic              irq
);
  dpStrobes_t strobes;
  logic statActive, statErr, statIrq;

  busdma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .addr(regAddr),
    .wrLow(regWrData[3:0]), .engDone(engDone), .engErr(engErr),
    .strobes(strobes), .startQ(engStart), .dirQ(engToMem),
    .activeQ(statActive), .errQ(statErr), .irqQ(statIrq)
  );

  busdma_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(regWrData),
    .addr(regAddr), .startQ(engStart), .dirQ(engToMem),
    .activeQ(statActive), .errQ(statErr), .irqQ(statIrq),
    .rdData(regRdData), .ptrOut(prdBase)
  );

  assign irq = statIrq;
endmodule

// File: rtl/busdma_regwin_chk.sv
module busdma_regwin_chk (
  input logic       clk,
  input logic       rstN,
  input logic       regWrEn,
  input logic [2:0] regAddr,
  input logic [7:0] regWrData,
  input logic [7:0] regRdData,
  input logic       engDone,
  input logic       engErr,
  input logic       engStart,
  input logic       irq,
  input logic       statActive
);
  AST_START_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regAddr == 3'd0 && regWrData[0] |=> engStart); // R2
  AST_ACTIVE_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regAddr == 3'd0 && regWrData[0] && !engStart |=> statActive); // R4
  AST_ACTIVE_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    statActive && (engDone || engErr) && !(regWrEn && regAddr == 3'd0) |=> !statActive); // R4
  AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    statActive && engDone |=> irq); // R5
  AST_IRQ_W1C: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regAddr == 3'd2 && regWrData[2] && !(statActive && engDone) |=> !irq); // R6
  AST_IRQ_PIN_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    regAddr == 3'd2 |-> irq == regRdData[2]); // R8
  AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    regAddr == 3'd4 |-> regRdData[1:0] == 2'b00); // R9
  AST_VENDOR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 3'd1 || regAddr == 3'd3) |-> regRdData == 8'h00); // R10
endmodule

bind busdma_regwin busdma_regwin_chk u_chk (.*);

// File: tb/busdma_regwin_tb.sv
`timescale 1ns/1ps
module busdma_regwin_tb;
  logic clk = 1'b0, rstN = 1'b0;
  logic regWrEn = 1'b0, engDone = 1'b0, engErr = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [7:0] regWrData = 8'h00, regRdData;
  logic engStart, engToMem, irq;
  logic [31:0] prdBase;
  int checks = 0, errors = 0;

  // reference model
  logic mStart = 0, mDir = 0, mAct = 0, mErr = 0, mIrq = 0;
  logic [1:0] mFlag = 0;
  logic [31:0] mPtr = 0;

  always #2.5 clk = ~clk;

  busdma_regwin u_dut (.*);

  function automatic logic [7:0] expRd(input logic [2:0] a);
    case (a)
      3'd0: return {4'b0, mDir, 2'b0, mStart};
      3'd2: return {1'b0, mFlag, 2'b0, mIrq, mErr, mAct};
      3'd4: return mPtr[7:0];
      3'd5: return mPtr[15:8];
      3'd6: return mPtr[23:16];
      3'd7: return mPtr[31:24];
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelStep(input logic wr, input logic [2:0] a, input logic [7:0] d,
                           input logic dn, input logic er);
    logic nAct, nErr, nIrq;
    nAct = mAct; nErr = mErr; nIrq = mIrq;
    if (wr && a == 3'd2) begin
      if (d[1]) nErr = 0;
      if (d[2]) nIrq = 0;
      mFlag = d[6:5];
    end
    if (mAct && (dn || er)) begin
      nAct = 0;
      if (dn) nIrq = 1;
      if (er) nErr = 1;
    end
    if (wr && a == 3'd0) begin
      if (d[0] && !mStart) nAct = 1;
      if (!d[0]) nAct = 0;
      if (!mStart) mDir = d[3];
      mStart = d[0];
    end
    if (wr && a >= 3'd4) mPtr[(a-3'd4)*8 +: 8] = (a == 3'd4) ? (d & 8'hFC) : d;
    mAct = nAct; mErr = nErr; mIrq = nIrq;
  endtask

  task automatic cyc(input logic wr, input logic [2:0] a, input logic [7:0] d,
                     input logic dn, input logic er);
    @(negedge clk);
    regWrEn = wr; regAddr = a; regWrData = d; engDone = dn; engErr = er;
    @(posedge clk);
    modelStep(wr, a, d, dn, er);
    #1;
    regWrEn = 0; engDone = 0; engErr = 0;
  endtask

  task automatic sweep(input string tag);
    for (int a = 0; a < 8; a++) begin
      regAddr = 3'(a);
      #0.1;
      check(tag, regRdData, expRd(3'(a)));
    end
    check({tag, " irq"}, irq, mIrq);
    check({tag, " start"}, engStart, mStart);
    check({tag, " dir"}, engToMem, mDir);
    check({tag, " ptr"}, prdBase, mPtr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    sweep("R1 reset");
    @(negedge clk); rstN = 1;
    @(posedge clk); #1;

    cyc(1, 3'd4, 8'h13, 0, 0); cyc(1, 3'd5, 8'h22, 0, 0);
    cyc(1, 3'd6, 8'h33, 0, 0); cyc(1, 3'd7, 8'h44, 0, 0);
    check("R9 ptr aligned", prdBase, 32'h44332210);
    sweep("R9");
    cyc(1, 3'd0, 8'h08, 0, 0);
    check("R2 dir", engToMem, 1'b1); check("R2 start low", engStart, 1'b0);
    cyc(1, 3'd0, 8'h09, 0, 0);
    regAddr = 3'd2; #0.1; check("R4 active set", regRdData, 8'h01);
    cyc(1, 3'd0, 8'h01, 0, 0);
    check("R3 dir locked", engToMem, 1'b1);
    cyc(0, 3'd0, 8'h00, 1, 0);
    check("R8 irq", irq, 1'b1);
    regAddr = 3'd2; #0.1; check("R5 done", regRdData, 8'h04);
    cyc(1, 3'd0, 8'h00, 0, 0);
    regAddr = 3'd2; #0.1; check("R11 good completion", regRdData[2:0], 3'b100);
    cyc(1, 3'd2, 8'h04, 0, 0);
    check("R6 w1c irq", irq, 1'b0);
    cyc(1, 3'd0, 8'h01, 0, 0);
    cyc(0, 3'd0, 8'h00, 0, 1);
    regAddr = 3'd2; #0.1; check("R5 err", regRdData, 8'h02);
    cyc(0, 3'd0, 8'h00, 1, 0);
    regAddr = 3'd2; #0.1; check("R5 inactive done ignored", regRdData, 8'h02);
    cyc(1, 3'd2, 8'h60, 0, 0);
    regAddr = 3'd2; #0.1; check("R7 flags, w0 keeps err", regRdData, 8'h62);
    cyc(1, 3'd2, 8'hFB, 0, 0);
    regAddr = 3'd2; #0.1; check("R7 ro bits", regRdData, 8'h60);
    cyc(1, 3'd1, 8'hFF, 0, 0); cyc(1, 3'd3, 8'hFF, 0, 0);
    sweep("R10 vendor");
    cyc(1, 3'd0, 8'h00, 0, 0); cyc(1, 3'd0, 8'h01, 0, 0);
    cyc(1, 3'd2, 8'h04, 1, 0);
    check("R6 set beats clear", irq, 1'b1);
    cyc(1, 3'd2, 8'h04, 0, 0);
    cyc(1, 3'd0, 8'h00, 0, 0); cyc(1, 3'd0, 8'h01, 0, 0);
    cyc(1, 3'd0, 8'h00, 0, 0);
    regAddr = 3'd2; #0.1; check("R4 stop clears active", regRdData[0], 1'b0);
    sweep("R4");

    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[0] | r[1], r[4:2], r[12:5], r[15:13] == 3'd0, r[18:16] == 3'd0);
      sweep("R2-random R5-random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule